// File: doc/BRIEF.md
# PCM Timeslot Drop/Insert Marker

This block follows bit and timeslot position on a shared serial PCM backplane, separately for the receive and transmit directions. Each direction advances one bit on every cycle of `clk` in which its bit-rate enable is high. It realigns to the frame whenever its own frame sync is sampled high. Two per-timeslot enable tables say which timeslots belong to this interface. From them the block drives a receive `drop` strobe and a transmit `insert` strobe, each high for whole timeslots. External logic uses these strobes to multiplex the backplane, because the block never three-states anything.

In transmit timeslots marked for insertion, the serial transmit output takes its bit from the alternate input `ins_dat` in place of the normal `tx_dat`. This replaces the source of an existing timeslot and adds none. Two frame formats are supported. With `e1_mode` low, a frame is 193 bits: one framing bit followed by 24 timeslots of 8 bits. With `e1_mode` high, a frame is 256 bits: 32 timeslots, the first of which starts at the frame boundary.

A one-cycle write port updates the tables. Each write goes to a staging copy, and the copy is adopted at the next frame start of that direction. A strobe therefore never changes in the middle of a timeslot because of a write.

Top module: `pcm_dropins_marker`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `drop`, `insert` and `tx_out` are 0 and both enable tables are cleared.
- R2: Each direction holds a bit position. An advance with sync high sets the position to 0. Any other advance adds 1, going back to 0 after position 192 when `e1_mode`=0 and after position 255 when `e1_mode`=1. A strobe of a single enabled timeslot therefore repeats every 193 or 256 bit periods.
- R3: `drop` is 1 for all 8 bits of every receive timeslot whose table entry is 1, and 0 for all other bits.
- R4: `insert` is 1 for all 8 bits of every transmit timeslot whose table entry is 1, and 0 for all other bits.
- R5: On each transmit advance, `tx_out` takes the value `ins_dat` had at that edge when the new bit lies in an inserted timeslot. Otherwise it takes the value `tx_dat` had.
- R6: With `e1_mode`=0, position 0 is the framing bit, and `drop` and `insert` are 0 during it whatever the tables hold. Timeslot n then occupies positions 1+8n to 8+8n.
- R7: With `e1_mode`=1, timeslot n occupies positions 8n to 8n+7, so timeslot 0 begins on the bit right after the sync.
- R8: A write (`cfg_we`=1) sets the entry at index `cfg_slot` to `cfg_en` in the receive table when `cfg_dir`=0, and in the transmit table when `cfg_dir`=1. It takes effect at that direction's next advance to position 0; a write on that very cycle is included.
- R9: Receive and transmit positions are independent. Sync and enable inputs of one direction never affect the other direction's outputs.
- R10: `drop` changes only on cycles with `rx_bit_en` high, and `insert` and `tx_out` change only on cycles with `tx_bit_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| e1_mode | input | 1 | 0: 193-bit frame with framing bit, 1: 256-bit frame |
| rx_bit_en | input | 1 | Receive bit-rate enable, one receive bit per high cycle |
| rx_sync | input | 1 | Receive frame sync, sampled on receive advances |
| tx_bit_en | input | 1 | Transmit bit-rate enable |
| tx_sync | input | 1 | Transmit frame sync, sampled on transmit advances |
| tx_dat | input | 1 | Normal transmit serial data |
| ins_dat | input | 1 | Alternate transmit serial data for inserted timeslots |
| cfg_we | input | 1 | Table write strobe |
| cfg_dir | input | 1 | Table select: 0 receive, 1 transmit |
| cfg_slot | input | 5 | Timeslot index written |
| cfg_en | input | 1 | Enable value written |
| drop | output | 1 | Receive timeslot ownership strobe |
| insert | output | 1 | Transmit timeslot ownership strobe |
| tx_out | output | 1 | Transmit serial data after source selection |

## Verification
Several properties are checked on every cycle. Outputs hold still between advances of their direction. `tx_out` matches whichever source the current `insert` value selects. Neither strobe is high during the framing bit. Only the bench scenarios can show the rest, because it needs knowledge of frame position and table history. That covers where each timeslot sits in the two frame formats, the 193-bit and 256-bit repeat periods, the delay of a table write until the next frame start, and the separation of receive and transmit timing. The bench covers these with a behavioural model that is compared on every clock.

// File: rtl/pcm_dropins_pkg.sv
package pcm_dropins_pkg;
  localparam int DEF_SLOT_BITS = 8;
  localparam int DEF_T1_SLOTS  = 24;
  localparam int DEF_E1_SLOTS  = 32;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } tbl_dir_e;
endpackage

// File: rtl/pcm_frame_pos.sv
module pcm_frame_pos #(
  parameter int POS_W  = 8,
  parameter int T1_LEN = 193,
  parameter int E1_LEN = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             sync,
  input  logic             e1_mode,
  output logic [POS_W-1:0] pos_nxt,
  output logic             frame_start
);
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] last_pos;

  assign last_pos = e1_mode ? POS_W'(E1_LEN - 1) : POS_W'(T1_LEN - 1);

  always_comb begin
    if (sync)                  pos_nxt = '0;
    else if (pos_q >= last_pos) pos_nxt = '0;
    else                       pos_nxt = pos_q + 1'b1;
  end

  assign frame_start = bit_en && (pos_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst)         pos_q <= '0;
    else if (bit_en) pos_q <= pos_nxt;
  end
endmodule

// File: rtl/pcm_slot_locate.sv
module pcm_slot_locate #(
  parameter int POS_W     = 8,
  parameter int ADDR_W    = 5,
  parameter int SLOT_BITS = 8
) (
  input  logic [POS_W-1:0]  pos,
  input  logic              e1_mode,
  output logic [ADDR_W-1:0] slot,
  output logic              fbit
);
  logic [POS_W-1:0] offset;

  // the 193-bit format shifts every timeslot one bit late behind the framing bit
  assign offset = e1_mode ? pos : pos - 1'b1;
  assign slot   = ADDR_W'(offset / POS_W'(SLOT_BITS));
  assign fbit   = !e1_mode && (pos == '0);
endmodule

// File: rtl/pcm_slot_table.sv
module pcm_slot_table #(
  parameter int ADDR_W = 5,
  parameter int SLOTS  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic              commit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);
  logic [SLOTS-1:0] staged_q, staged_nxt;
  logic [SLOTS-1:0] live_q, live_nxt;

  always_comb begin
    staged_nxt = staged_q;
    if (wr_en) staged_nxt[wr_addr] = wr_bit;
  end

  assign live_nxt = commit ? staged_nxt : live_q;
  assign rd_bit   = live_nxt[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      staged_q <= '0;
      live_q   <= '0;
    end else begin
      staged_q <= staged_nxt;
      live_q   <= live_nxt;
    end
  end
endmodule

// File: rtl/pcm_dropins_marker.sv
module pcm_dropins_marker
  import pcm_dropins_pkg::*;
#(
  parameter int SLOT_BITS = DEF_SLOT_BITS,
  parameter int T1_SLOTS  = DEF_T1_SLOTS,
  parameter int E1_SLOTS  = DEF_E1_SLOTS,
  localparam int ADDR_W   = $clog2(E1_SLOTS),
  localparam int T1_LEN   = T1_SLOTS * SLOT_BITS + 1,
  localparam int E1_LEN   = E1_SLOTS * SLOT_BITS,
  localparam int MAX_LEN  = (E1_LEN > T1_LEN) ? E1_LEN : T1_LEN,
  localparam int POS_W    = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              e1_mode,
  input  logic              rx_bit_en,
  input  logic              rx_sync,
  input  logic              tx_bit_en,
  input  logic              tx_sync,
  input  logic              tx_dat,
  input  logic              ins_dat,
  input  logic              cfg_we,
  input  logic              cfg_dir,
  input  logic [ADDR_W-1:0] cfg_slot,
  input  logic              cfg_en,
  output logic              drop,
  output logic              insert,
  output logic              tx_out
);
  logic [1:0]        bit_en_v, sync_v, fstart, fbit, en_bit, mark, strobe_q;
  logic [POS_W-1:0]  pos_nxt [2];
  logic [ADDR_W-1:0] slot [2];

  assign bit_en_v = {tx_bit_en, rx_bit_en};
  assign sync_v   = {tx_sync, rx_sync};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    pcm_frame_pos #(.POS_W(POS_W), .T1_LEN(T1_LEN), .E1_LEN(E1_LEN)) u_pos (
      .clk(clk), .rst(rst), .bit_en(bit_en_v[d]), .sync(sync_v[d]),
      .e1_mode(e1_mode), .pos_nxt(pos_nxt[d]), .frame_start(fstart[d])
    );

    pcm_slot_locate #(.POS_W(POS_W), .ADDR_W(ADDR_W), .SLOT_BITS(SLOT_BITS)) u_loc (
      .pos(pos_nxt[d]), .e1_mode(e1_mode), .slot(slot[d]), .fbit(fbit[d])
    );

    pcm_slot_table #(.ADDR_W(ADDR_W), .SLOTS(E1_SLOTS)) u_tbl (
      .clk(clk), .rst(rst),
      .wr_en(cfg_we && (cfg_dir == ((d == 0) ? DIR_RX : DIR_TX))),
      .wr_addr(cfg_slot), .wr_bit(cfg_en),
      .commit(fstart[d]), .rd_addr(slot[d]), .rd_bit(en_bit[d])
    );

    assign mark[d] = en_bit[d] && !fbit[d];

    always_ff @(posedge clk) begin
      if (rst)              strobe_q[d] <= 1'b0;
      else if (bit_en_v[d]) strobe_q[d] <= mark[d];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            tx_out <= 1'b0;
    else if (tx_bit_en) tx_out <= mark[1] ? ins_dat : tx_dat;
  end

  assign drop   = strobe_q[0];
  assign insert = strobe_q[1];
endmodule

// File: rtl/pcm_dropins_chk.sv
module pcm_dropins_chk (
  input logic clk,
  input logic rst,
  input logic rx_bit_en,
  input logic tx_bit_en,
  input logic tx_dat,
  input logic ins_dat,
  input logic rx_fbit,
  input logic tx_fbit,
  input logic drop,
  input logic insert,
  input logic tx_out
);
  // R10
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_bit_en |=> $stable(drop));

  // R10
  insert_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_bit_en |=> ($stable(insert) && $stable(tx_out)));

  // R5
  tx_source_chk: assert property (@(posedge clk) disable iff (rst)
    tx_bit_en |=> (tx_out == (insert ? $past(ins_dat) : $past(tx_dat))));

  // R6
  rx_fbit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_bit_en && rx_fbit) |=> !drop);

  // R6
  tx_fbit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_bit_en && tx_fbit) |=> !insert);
endmodule

bind pcm_dropins_marker pcm_dropins_chk u_chk (
  .clk(clk), .rst(rst), .rx_bit_en(rx_bit_en), .tx_bit_en(tx_bit_en),
  .tx_dat(tx_dat), .ins_dat(ins_dat), .rx_fbit(fbit[0]), .tx_fbit(fbit[1]),
  .drop(drop), .insert(insert), .tx_out(tx_out)
);

// File: tb/pcm_dropins_marker_test.sv
module pcm_dropins_marker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic e1_mode = 1'b0;
  logic rx_bit_en = 1'b0, rx_sync = 1'b0, tx_bit_en = 1'b0, tx_sync = 1'b0;
  logic tx_dat = 1'b0, ins_dat = 1'b0;
  logic cfg_we = 1'b0, cfg_dir = 1'b0, cfg_en = 1'b0;
  logic [4:0] cfg_slot = '0;
  logic drop, insert, tx_out;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pcm_dropins_marker uut (
    .clk(clk), .rst(rst), .e1_mode(e1_mode),
    .rx_bit_en(rx_bit_en), .rx_sync(rx_sync),
    .tx_bit_en(tx_bit_en), .tx_sync(tx_sync),
    .tx_dat(tx_dat), .ins_dat(ins_dat),
    .cfg_we(cfg_we), .cfg_dir(cfg_dir), .cfg_slot(cfg_slot), .cfg_en(cfg_en),
    .drop(drop), .insert(insert), .tx_out(tx_out)
  );

  // behavioural reference
  int rpos, tpos;
  bit [31:0] sh_rx, sh_tx, act_rx, act_tx;
  bit m_drop, m_ins, m_tx;

  function automatic bit owned(bit [31:0] tbl, int p, bit e1);
    if (!e1 && p == 0) return 1'b0;
    return tbl[e1 ? p / 8 : (p - 1) / 8];
  endfunction

  function automatic int advance(int p, bit s, bit e1);
    int len = e1 ? 256 : 193;
    if (s) return 0;
    return (p >= len - 1) ? 0 : p + 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      rpos = 0; tpos = 0;
      sh_rx = '0; sh_tx = '0; act_rx = '0; act_tx = '0;
      m_drop = 0; m_ins = 0; m_tx = 0;
    end else begin
      if (cfg_we) begin
        if (cfg_dir) sh_tx[cfg_slot] = cfg_en;
        else         sh_rx[cfg_slot] = cfg_en;
      end
      if (rx_bit_en) begin
        rpos = advance(rpos, rx_sync, e1_mode);
        if (rpos == 0) act_rx = sh_rx;
        m_drop = owned(act_rx, rpos, e1_mode);
      end
      if (tx_bit_en) begin
        tpos = advance(tpos, tx_sync, e1_mode);
        if (tpos == 0) act_tx = sh_tx;
        m_ins = owned(act_tx, tpos, e1_mode);
        m_tx  = m_ins ? ins_dat : tx_dat;
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (!rst) begin
      chk("R3 drop vs model", drop, m_drop);
      chk("R4 insert vs model", insert, m_ins);
      chk("R5 tx_out vs model", tx_out, m_tx);
    end
  endtask

  task automatic wr(bit dir, int s, bit en);
    cfg_we = 1; cfg_dir = dir; cfg_slot = 5'(s); cfg_en = en;
    step();
    cfg_we = 0;
  endtask

  initial begin
    int rise1, rise2;
    logic prev, hold_i, hold_t;
    repeat (3) step();
    chk("R1 drop in reset", drop, 1'b0);
    chk("R1 insert in reset", insert, 1'b0);
    rst = 0;
    step();
    chk("R1 drop after reset", drop, 1'b0);
    chk("R1 insert after reset", insert, 1'b0);
    chk("R1 tx_out after reset", tx_out, 1'b0);

    // 193-bit format
    rx_bit_en = 1; tx_bit_en = 1; ins_dat = 1; tx_dat = 0;
    wr(1'b0, 0, 1'b1);
    wr(1'b1, 1, 1'b1);
    rx_sync = 1; tx_sync = 1;
    step();
    rx_sync = 0; tx_sync = 0;
    chk("R6 framing bit drop low", drop, 1'b0);
    chk("R6 framing bit insert low", insert, 1'b0);
    rise1 = -1; rise2 = -1; prev = drop;
    for (int i = 1; i <= 400; i++) begin
      step();
      if (drop && !prev) begin
        if (rise1 < 0) rise1 = i; else if (rise2 < 0) rise2 = i;
      end
      prev = drop;
      if (i == 1) chk("R6 slot0 starts at bit 1", drop, 1'b1);
      if (i == 8) begin
        chk("R3 slot0 last bit", drop, 1'b1);
        chk("R5 normal source", tx_out, 1'b0);
      end
      if (i == 9) begin
        chk("R3 slot0 ended", drop, 1'b0);
        chk("R4 slot1 inserted", insert, 1'b1);
        chk("R5 alternate source", tx_out, 1'b1);
      end
      if (i == 17) chk("R8 write not yet live", drop, 1'b0);
      if (i == 193) chk("R6 second framing bit", drop, 1'b0);
      if (i == 193 + 17) chk("R8 write live next frame", drop, 1'b1);
      if (i == 5) begin cfg_we = 1; cfg_dir = 0; cfg_slot = 5'd2; cfg_en = 1; end
      else cfg_we = 0;
    end
    tests++;
    if (rise2 - rise1 != 193) begin
      fails++;
      $display("FAIL R2 193-bit period: actual %0d expected 193", rise2 - rise1);
    end

    // 256-bit format
    e1_mode = 1;
    rx_sync = 1; tx_sync = 1;
    step();
    rx_sync = 0; tx_sync = 0;
    chk("R7 slot0 at first bit", drop, 1'b1);
    rise1 = 0; rise2 = -1; prev = drop;
    for (int i = 1; i <= 300; i++) begin
      step();
      if (drop && !prev && i > 200 && rise2 < 0) rise2 = i;
      prev = drop;
      if (i == 7)  chk("R7 slot0 last bit", drop, 1'b1);
      if (i == 8)  begin chk("R7 slot0 ended", drop, 1'b0); chk("R4 slot1 e1", insert, 1'b1); end
      if (i == 16) chk("R7 slot2 at bit 16", drop, 1'b1);
    end
    tests++;
    if (rise2 - rise1 != 256) begin
      fails++;
      $display("FAIL R2 256-bit period: actual %0d expected 256", rise2 - rise1);
    end

    // independence and hold: transmit stalled while receive resyncs
    tx_bit_en = 0;
    hold_i = insert; hold_t = tx_out;
    for (int i = 0; i < 40; i++) begin
      rx_sync = (i % 13 == 0);
      tx_sync = (i % 7 == 0);
      tx_dat = ~tx_dat; ins_dat = ~ins_dat;
      step();
    end
    rx_sync = 0; tx_sync = 0;
    chk("R10 insert held", insert, hold_i);
    chk("R9 tx_out unaffected", tx_out, hold_t);

    // randomised traffic with rolling table edits
    for (int i = 0; i < 6000; i++) begin
      rx_bit_en = ($urandom_range(0, 3) != 0);
      tx_bit_en = ($urandom_range(0, 2) != 0);
      rx_sync = ($urandom_range(0, 499) == 0);
      tx_sync = ($urandom_range(0, 499) == 0);
      tx_dat = 1'($urandom); ins_dat = 1'($urandom);
      cfg_we = ($urandom_range(0, 19) == 0);
      cfg_dir = 1'($urandom); cfg_slot = 5'($urandom); cfg_en = 1'($urandom);
      if (i == 3000) e1_mode = 0;
      if (i >= 3000 && i < 3002) begin rx_sync = 1; tx_sync = 1; rx_bit_en = 1; tx_bit_en = 1; end
      step();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule